// File: doc/BRIEF.md
# Processor interrupt level arbiter

This block chooses which external interrupt level, if any, is offered to a processor core. It merges a 16-bit vector of hardware level requests with a software-interrupt register, compares the result against the core's current interrupt level, and produces a registered request flag together with a trap-type index. The request is raised, moved to a new index, or withdrawn whenever its inputs call for it. Each decision takes one clock.

The software-interrupt register is 17 bits wide. Bits 15:1 request the levels of the same number. Bit 0 is the tick timer flag and bit 16 is the system-tick timer flag. Neither timer bit requests its own level; either one forces level 14. A vectored interrupt in flight outranks every level interrupt and freezes the outputs. When the core is already servicing a higher external trap at a nonzero trap level, a new request is held back.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `irq_req` is 0 and `irq_idx` is 0 until a pending level is evaluated.
- R2: The pending vector is `lvl_req` ORed with `soft_int[15:1]`. Bit 0 of `soft_int` (tick) and bit 16 (system tick) do not request their own level positions.
- R3: If `soft_int[0]` or `soft_int[16]` is 1, level 14 is pending.
- R4: In any cycle where `vec_busy` is 1, `irq_req` and `irq_idx` keep their values at the next edge, whatever the other inputs do.
- R5: If the pending vector has no bit above `cur_lvl` (for example, `cur_lvl` = 15 always has none), then one cycle later `irq_req` is 0 and `irq_idx` is 0.
- R6: With interrupts enabled, the highest pending level L above `cur_lvl` gives `irq_idx` = 0x40 | L (so 0x41 to 0x4F) and `irq_req` = 1 one cycle later.
- R7: If `trap_lvl` is nonzero, `top_tt[8:4]` equals 0x04, and `top_tt` is greater than the candidate index of R6, then the outputs are held. If any of these three conditions fails, R6 applies.
- R8: When `int_en` is 0 and `vec_busy` is 0, then one cycle later `irq_req` is 0 and `irq_idx` is 0.
- R9: When the candidate index equals the index already presented, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 16 | Hardware level request vector |
| soft_int | input | 17 | Software-interrupt register contents |
| cur_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| top_tt | input | 9 | Trap type at the top of the trap stack |
| vec_busy | input | 1 | Vectored interrupt in flight |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 9 | Trap-type index of the request |

## Verification
Several conditions can hold in the same cycle, and they compete for control of the outputs. The first such collision is between the nesting guard and a fresh, higher candidate: the bench places a servicing trap type above the candidate while new levels arrive, then varies each of the three guard terms in turn. The second collision is between a vectored interrupt in flight and a disable or a drop below threshold in the same cycle, where the freeze must win. Random cycles that often combine these conditions are compared against a bench reference model. That model applies the precedence order busy, then threshold, then enable, then guard, then the index change.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int LVL_N_D = 16;
  localparam int SW_W_D  = 17;
  localparam int TT_W_D  = 9;
  localparam int TL_W_D  = 3;
  localparam int TICK_BIT_D  = 0;
  localparam int STICK_BIT_D = 16;
  localparam int FORCE_LVL_D = 14;
  localparam logic [TT_W_D-1:0] EXT_BASE_D = 9'h040;
endpackage

// File: rtl/irqarb_pend_merge.sv
module irqarb_pend_merge #(
  parameter int LVL_N     = 16,
  parameter int SW_W      = 17,
  parameter int TICK_BIT  = 0,
  parameter int STICK_BIT = 16,
  parameter int FORCE_LVL = 14
) (
  input  logic [LVL_N-1:0] lvl_req,
  input  logic [SW_W-1:0]  soft_int,
  output logic [LVL_N-1:0] pend
);
  logic timer_hit;
  assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

  for (genvar i = 0; i < LVL_N; i++) begin : g_bit
    logic soft_part;
    if (i == TICK_BIT || i == STICK_BIT || i >= SW_W) begin : g_timer_slot
      assign soft_part = 1'b0;
    end else begin : g_soft_slot
      assign soft_part = soft_int[i];
    end
    if (i == FORCE_LVL) begin : g_forced
      assign pend[i] = lvl_req[i] | soft_part | timer_hit;
    end else begin : g_plain
      assign pend[i] = lvl_req[i] | soft_part;
    end
  end
endmodule

// File: rtl/irqarb_level_scan.sv
module irqarb_level_scan #(
  parameter int LVL_N = 16,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic [LVL_N-1:0] pend,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             any_above,
  output logic [LVL_W-1:0] top_lvl
);
  logic [LVL_N-1:0] above;

  for (genvar i = 0; i < LVL_N; i++) begin : g_mask
    assign above[i] = pend[i] && (cur_lvl < LVL_W'(i));
  end

  assign any_above = |above;

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (above[i]) top_lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irqarb_nest_guard.sv
module irqarb_nest_guard #(
  parameter int TT_W = 9,
  parameter int TL_W = 3,
  parameter int LVL_W = 4,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040
) (
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TT_W-1:0] top_tt,
  input  logic [TT_W-1:0] cand_idx,
  output logic            hold_off
);
  logic nested, ext_class, outranks;
  assign nested    = |trap_lvl;
  assign ext_class = top_tt[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W];
  assign outranks  = top_tt > cand_idx;
  assign hold_off  = nested && ext_class && outranks;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irqarb_pkg::*;
#(
  parameter int LVL_N     = LVL_N_D,
  parameter int SW_W      = SW_W_D,
  parameter int TT_W      = TT_W_D,
  parameter int TL_W      = TL_W_D,
  parameter int TICK_BIT  = TICK_BIT_D,
  parameter int STICK_BIT = STICK_BIT_D,
  parameter int FORCE_LVL = FORCE_LVL_D,
  parameter logic [TT_W-1:0] EXT_BASE = EXT_BASE_D,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] lvl_req,
  input  logic [SW_W-1:0]  soft_int,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             int_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  top_tt,
  input  logic             vec_busy,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_idx
);
  logic [LVL_N-1:0] pend;
  logic             any_above;
  logic [LVL_W-1:0] top_lvl;
  logic [TT_W-1:0]  cand_idx;
  logic             hold_off;

  logic             req_q, req_d;
  logic [TT_W-1:0]  idx_q, idx_d;
  logic             ld_en;

  irqarb_pend_merge #(
    .LVL_N(LVL_N), .SW_W(SW_W), .TICK_BIT(TICK_BIT),
    .STICK_BIT(STICK_BIT), .FORCE_LVL(FORCE_LVL)
  ) u_merge (
    .lvl_req(lvl_req), .soft_int(soft_int), .pend(pend)
  );

  irqarb_level_scan #(.LVL_N(LVL_N)) u_scan (
    .pend(pend), .cur_lvl(cur_lvl), .any_above(any_above), .top_lvl(top_lvl)
  );

  assign cand_idx = EXT_BASE | TT_W'(top_lvl);

  irqarb_nest_guard #(
    .TT_W(TT_W), .TL_W(TL_W), .LVL_W(LVL_W), .EXT_BASE(EXT_BASE)
  ) u_guard (
    .trap_lvl(trap_lvl), .top_tt(top_tt), .cand_idx(cand_idx), .hold_off(hold_off)
  );

  // next-state: a vectored interrupt freezes everything
  assign ld_en = !vec_busy;

  always_comb begin
    req_d = req_q;
    idx_d = idx_q;
    if (!any_above || !int_en) begin
      req_d = 1'b0;
      idx_d = '0;
    end else if (!hold_off && (cand_idx != idx_q)) begin
      req_d = 1'b1;
      idx_d = cand_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else if (ld_en) begin
      req_q <= req_d;
      idx_q <= idx_d;
    end
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |=> (irq_req == $past(irq_req) && irq_idx == $past(irq_idx))); // R4

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !int_en) |=> (!irq_req && irq_idx == '0)); // R8

  AST_IDX_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_idx[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W] &&
                 irq_idx[LVL_W-1:0] != '0)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_idx == '0); // R5

  AST_NEW_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_idx != $past(irq_idx)) |-> irq_idx[LVL_W-1:0] > $past(cur_lvl)); // R6

  AST_NEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && int_en && any_above && hold_off) |=> $stable(irq_idx)); // R7
endmodule

// File: tb/irq_level_arbiter_tb.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lvl_req;
  logic [16:0] soft_int;
  logic [3:0]  cur_lvl;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  top_tt;
  logic        vec_busy;
  logic        irq_req;
  logic [8:0]  irq_idx;

  int total = 0;
  int bad = 0;
  logic       m_req;
  logic [8:0] m_idx;
  string      m_tag;

  always #2.5 clk = ~clk;

  irq_level_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .soft_int(soft_int),
    .cur_lvl(cur_lvl), .int_en(int_en), .trap_lvl(trap_lvl), .top_tt(top_tt),
    .vec_busy(vec_busy), .irq_req(irq_req), .irq_idx(irq_idx)
  );

  // reference model of one clock step; updates m_req/m_idx and m_tag
  task automatic model_step();
    logic [15:0] p;
    logic [8:0]  cand;
    int          top;
    p = lvl_req | (soft_int[15:0] & 16'hFFFE);
    if (soft_int[0] | soft_int[16]) p[14] = 1'b1;
    if (vec_busy) begin
      m_tag = "R4";
    end else if ({1'b0, p} < (17'd2 << cur_lvl)) begin
      m_tag = "R5"; m_req = 1'b0; m_idx = '0;
    end else if (!int_en) begin
      m_tag = "R8"; m_req = 1'b0; m_idx = '0;
    end else begin
      top = 0;
      for (int i = 15; i >= 0; i--) if (p[i] && top == 0) top = i;
      cand = 9'h040 | 9'(top);
      if (trap_lvl != 0 && top_tt[8:4] == 5'h04 && top_tt > cand) begin
        m_tag = "R7";
      end else if (cand != m_idx) begin
        m_tag = "R6"; m_req = 1'b1; m_idx = cand;
      end else begin
        m_tag = "R9";
      end
    end
  endtask

  task automatic compare(input string tag);
    total++;
    if (irq_req !== m_req || irq_idx !== m_idx) begin
      bad++;
      $display("FAIL %s: got req=%0b idx=%h, expected req=%0b idx=%h",
               tag, irq_req, irq_idx, m_req, m_idx);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag == "" ? m_tag : tag);
  endtask

  task automatic set_in(input logic [15:0] h, input logic [16:0] s, input logic [3:0] c,
                        input logic e, input logic [2:0] tl, input logic [8:0] tt,
                        input logic b);
    lvl_req = h; soft_int = s; cur_lvl = c; int_en = e;
    trap_lvl = tl; top_tt = tt; vec_busy = b;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    m_req = 1'b0; m_idx = '0;
    set_in(16'h0020, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    set_in(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    @(negedge clk);
    compare("R1");

    // R6: highest above current level
    set_in(16'h0020, 17'h0, 4'd3, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R6");
    cycle("R9");
    set_in(16'h0220, 17'h0, 4'd3, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R6");
    set_in(16'h0220, 17'h0, 4'd9, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R5");
    // R3: timer bits fold into level 14
    set_in(16'h0000, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R3");
    set_in(16'h0000, 17'h00000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R5");
    set_in(16'h0000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R3");
    set_in(16'h0000, 17'h00001, 4'd14, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R3");
    // R2: software level bits merge
    set_in(16'h0000, 17'h00008, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R2");
    set_in(16'h0004, 17'h08001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R2");
    // R7: nesting suppression and each failing term
    set_in(16'h0040, 17'h0, 4'd0, 1'b1, 3'd1, 9'h04A, 1'b0); cycle("R7");
    set_in(16'h0040, 17'h0, 4'd0, 1'b1, 3'd0, 9'h04A, 1'b0); cycle("R7");
    set_in(16'h0080, 17'h0, 4'd0, 1'b1, 3'd1, 9'h14A, 1'b0); cycle("R7");
    set_in(16'h0100, 17'h0, 4'd0, 1'b1, 3'd1, 9'h043, 1'b0); cycle("R7");
    // R4 busy freeze, then R8 disable
    set_in(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1); cycle("R4");
    set_in(16'h8000, 17'h0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b1); cycle("R4");
    set_in(16'h8000, 17'h0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0); cycle("R8");
    set_in(16'h8000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R6");
    set_in(16'hFFFF, 17'h1FFFF, 4'd15, 1'b1, 3'd0, 9'h0, 1'b0); cycle("R5");

    for (int n = 0; n < 4000; n++) begin
      logic [16:0] s;
      logic [8:0]  tt;
      s = 17'($urandom & $urandom) & 17'h0FFFE;
      if ($urandom_range(0, 3) == 0) s[0] = 1'b1;
      if ($urandom_range(0, 3) == 0) s[16] = 1'b1;
      tt = ($urandom_range(0, 3) != 0) ? (9'h040 | 9'($urandom_range(0, 15)))
                                       : 9'($urandom);
      set_in(16'($urandom & $urandom), s, 4'($urandom_range(0, 15)),
             $urandom_range(0, 7) != 0, 3'($urandom_range(0, 1) * $urandom_range(1, 7)),
             tt, $urandom_range(0, 7) == 0);
      cycle("");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule